// File: doc/BRIEF.md
# Variable-Element-Width Vector Register Sequencer

This block runs a scalar register operation as a sequence of element operations over a register file. The register file is treated as one packed, byte-addressed store. A register number marks only where an operand begins in that store. A separate element count sets how many elements are processed. A 2-bit width code per operand sets each element's size. Elements may therefore cross the boundary between two registers.

Each of the three operands (one destination, two sources) is described by a 16-bit configuration word. The bit positions in that word are:

- bit 15: vector flag
- bits [14:8]: register number
- bit 7: type bit
- bits [6:5]: width code
- bits [4:0]: key

Only the vector flag, register number and width code affect this block. On every clock of an operation the block works on one element. It computes a byte offset and a lane size for each operand, reads both sources and sign-extends them to full register width. It adds them, and writes the low bytes of the sum back into the destination element only. The operation here is a plain add, so that the sequencing can be exercised.

A host port loads a whole register while the block is idle. A combinational read port returns any whole register.

Top module: `vew_seq`

## Requirements
- R1: The width is decoded from config bits [6:5] only: code 0 gives XLEN bits, 1 gives 8, 2 gives 16 and 3 gives 32. Bit 7 never changes the width, even when an out-of-range code OR-ed into the word has spilled into it.
- R2: Config bits [14:8] give the starting register and bit 15 the vector flag. The starting byte is register number times XLEN/8, and store bytes are little-endian within a register.
- R3: Element i of a vector operand occupies the bytes starting at start_byte + i*(width/8), so consecutive elements continue across register boundaries.
- R4: An operand with the vector flag clear uses the same element at its start byte on every iteration.
- R5: Sources narrower than XLEN are sign-extended before the add. The sum is truncated to the destination element width.
- R6: A destination write changes only the bytes of that element. All other bytes of the store keep their value.
- R7: After start is accepted, one element is processed per clock. done is high for exactly one cycle, VL clock edges after the accepting edge, and busy is high from the accepting edge until done.
- R8: With VL=0, done is high in the cycle right after the accepting edge, busy stays low and the store is unchanged.
- R9: If any operand's element would extend past the last byte of the store, that element's write is suppressed. err then goes high and stays high until the next accepted start clears it.
- R10: start and host loads are ignored while busy. They neither alter the running operation nor change the store.
- R11: After reset, busy, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| vl | input | VLW | Number of elements |
| cfg_dst | input | 16 | Destination configuration word |
| cfg_src1 | input | 16 | First source configuration word |
| cfg_src2 | input | 16 | Second source configuration word |
| ld_en | input | 1 | Host load of one whole register (idle only) |
| ld_reg | input | log2(NREGS) | Register to load |
| ld_data | input | XLEN | Data to load |
| rd_reg | input | log2(NREGS) | Register to read |
| rd_data | output | XLEN | Combinational contents of rd_reg |
| busy | output | 1 | Element loop running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Out-of-range element seen in the last operation |

## Verification
An operation of VL elements raises done exactly VL edges after the edge that accepts start. done is high in the next cycle when VL is zero. The bench counts falling edges from the accepting edge until done appears, and compares that count with VL. It then checks that done has fallen one cycle later. The store contents and err are examined only after done, once the design is idle. rd_data is combinational from rd_reg, so each register is read one time step after the monitor sets the address, away from any clock edge.

// File: rtl/vew_pkg.sv
package vew_pkg;

  localparam int NBW = 8;  // width of a lane byte count

  typedef struct packed {
    logic       vec;   // [15] vector operand
    logic [6:0] ridx;  // [14:8] starting register
    logic       kind;  // [7] type bit, unused here
    logic [1:0] ew;    // [6:5] width code
    logic [4:0] tag;   // [4:0] key, unused here
  } vew_cfg_t;

  function automatic logic [NBW-1:0] ew_nbytes(input logic [1:0] ew, input int unsigned xbytes);
    case (ew)
      2'd1:    return NBW'(1);
      2'd2:    return NBW'(2);
      2'd3:    return NBW'(4);
      default: return NBW'(xbytes);
    endcase
  endfunction

endpackage

// File: rtl/vew_addr_gen.sv
module vew_addr_gen
  import vew_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int VLW   = 8,
  parameter int OFW   = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  vew_cfg_t       cfg,
  input  logic [VLW-1:0] idx,
  output logic [OFW-1:0] off,
  output logic [NBW-1:0] nbytes,
  output logic           oob
);
  localparam int XB = XLEN / 8;
  localparam int SB = NREGS * XB;

  logic [OFW-1:0] base, step, elem_end;

  always_comb begin
    nbytes   = ew_nbytes(cfg.ew, XB);
    base     = OFW'(cfg.ridx) * OFW'(XB);
    step     = cfg.vec ? OFW'(idx) * OFW'(nbytes) : '0;
    off      = base + step;
    elem_end = off + OFW'(nbytes);
    oob      = elem_end > OFW'(SB);
  end

  // R1: every width code maps to a single power-of-two lane size
  p_lane_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(nbytes));

endmodule

// File: rtl/vew_ctrl.sv
module vew_ctrl #(
  parameter int VLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  output logic           accept,
  output logic           busy,
  output logic [VLW-1:0] idx,
  output logic           done
);
  logic           busy_q, busy_d, done_q, done_d;
  logic [VLW-1:0] idx_q, idx_d, vl_q, vl_d;

  always_comb begin
    accept = start && !busy_q;
    busy_d = busy_q;
    idx_d  = idx_q;
    vl_d   = vl_q;
    done_d = 1'b0;
    if (accept) begin
      vl_d  = vl;
      idx_d = '0;
      if (vl == '0) done_d = 1'b1;
      else          busy_d = 1'b1;
    end else if (busy_q) begin
      if (idx_q == vl_q - VLW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + VLW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      vl_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      vl_q   <= vl_d;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
  assign done = done_q;

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_busy_ends_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  p_idx_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (idx_q == $past(idx_q) + VLW'(1)));
  p_empty_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q && vl == '0) |=> (done_q && !busy_q));
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && idx_q != vl_q - VLW'(1)) |=> (busy_q && $stable(vl_q)));

endmodule

// File: rtl/vew_store.sv
module vew_store
  import vew_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int AW    = 8,
  parameter int RIW   = 5
) (
  input  logic                      clk,
  input  logic                      ld_en,
  input  logic [RIW-1:0]            ld_reg,
  input  logic [XLEN-1:0]           ld_data,
  input  logic [RIW-1:0]            rd_reg,
  output logic [XLEN-1:0]           rd_data,
  input  logic [1:0][AW-1:0]        src_off,
  input  logic [1:0][1:0]           src_ew,
  input  logic [1:0][NBW-1:0]       src_nb,
  output logic [1:0][XLEN-1:0]      src_val,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_off,
  input  logic [NBW-1:0]            wr_nb,
  input  logic [XLEN-1:0]           wr_data
);
  localparam int XB = XLEN / 8;
  localparam int SB = NREGS * XB;

  logic [7:0] mem [SB];

  for (genvar s = 0; s < 2; s++) begin : g_rd
    logic [XLEN-1:0] raw, ext;
    always_comb begin
      for (int b = 0; b < XB; b++)
        raw[8*b +: 8] = (NBW'(b) < src_nb[s]) ? mem[src_off[s] + AW'(b)] : 8'h00;
      case (src_ew[s])
        2'd1:    ext = {{(XLEN-8){raw[7]}},   raw[7:0]};
        2'd2:    ext = {{(XLEN-16){raw[15]}}, raw[15:0]};
        2'd3:    ext = {{(XLEN-32){raw[31]}}, raw[31:0]};
        default: ext = raw;
      endcase
    end
    assign src_val[s] = ext;
  end

  always_comb begin
    for (int b = 0; b < XB; b++)
      rd_data[8*b +: 8] = mem[AW'(rd_reg) * AW'(XB) + AW'(b)];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < XB; b++)
        if (NBW'(b) < wr_nb) mem[wr_off + AW'(b)] <= wr_data[8*b +: 8];
    end else if (ld_en) begin
      for (int b = 0; b < XB; b++)
        mem[AW'(ld_reg) * AW'(XB) + AW'(b)] <= ld_data[8*b +: 8];
    end
  end

endmodule

// File: rtl/vew_seq.sv
module vew_seq
  import vew_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int VLW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [VLW-1:0]           vl,
  input  logic [15:0]              cfg_dst,
  input  logic [15:0]              cfg_src1,
  input  logic [15:0]              cfg_src2,
  input  logic                     ld_en,
  input  logic [$clog2(NREGS)-1:0] ld_reg,
  input  logic [XLEN-1:0]          ld_data,
  input  logic [$clog2(NREGS)-1:0] rd_reg,
  output logic [XLEN-1:0]          rd_data,
  output logic                     busy,
  output logic                     done,
  output logic                     err
);
  localparam int XB  = XLEN / 8;
  localparam int SB  = NREGS * XB;
  localparam int AW  = $clog2(SB);
  localparam int RIW = $clog2(NREGS);
  localparam int OFW = VLW + 7 + $clog2(XB) + 2;
  localparam int NOP = 3;  // 0 destination, 1 first source, 2 second source

  logic           accept;
  logic [VLW-1:0] idx;
  vew_cfg_t       cfg_in [NOP];
  vew_cfg_t       cfg_q  [NOP];
  logic [OFW-1:0] off_w  [NOP];
  logic [NBW-1:0] nb_w   [NOP];
  logic [NOP-1:0] oob_w;
  logic           any_oob, err_q, err_d;
  logic [1:0][AW-1:0]   s_off;
  logic [1:0][1:0]      s_ew;
  logic [1:0][NBW-1:0]  s_nb;
  logic [1:0][XLEN-1:0] s_val;
  logic [XLEN-1:0]      sum;

  assign cfg_in[0] = vew_cfg_t'(cfg_dst);
  assign cfg_in[1] = vew_cfg_t'(cfg_src1);
  assign cfg_in[2] = vew_cfg_t'(cfg_src2);

  vew_ctrl #(.VLW(VLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .accept(accept), .busy(busy), .idx(idx), .done(done)
  );

  for (genvar k = 0; k < NOP; k++) begin : g_op
    vew_addr_gen #(.XLEN(XLEN), .NREGS(NREGS), .VLW(VLW), .OFW(OFW)) u_agen (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q[k]), .idx(idx),
      .off(off_w[k]), .nbytes(nb_w[k]), .oob(oob_w[k])
    );
  end

  for (genvar s = 0; s < 2; s++) begin : g_src
    assign s_off[s] = AW'(off_w[s+1]);
    assign s_ew[s]  = cfg_q[s+1].ew;
    assign s_nb[s]  = nb_w[s+1];
  end

  assign any_oob = |oob_w;
  assign sum     = s_val[0] + s_val[1];

  vew_store #(.XLEN(XLEN), .NREGS(NREGS), .AW(AW), .RIW(RIW)) u_store (
    .clk(clk),
    .ld_en(ld_en && !busy), .ld_reg(ld_reg), .ld_data(ld_data),
    .rd_reg(rd_reg), .rd_data(rd_data),
    .src_off(s_off), .src_ew(s_ew), .src_nb(s_nb), .src_val(s_val),
    .wr_en(busy && !any_oob), .wr_off(AW'(off_w[0])), .wr_nb(nb_w[0]), .wr_data(sum)
  );

  always_comb begin
    err_d = err_q;
    if (accept)                err_d = 1'b0;
    else if (busy && any_oob)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      for (int k = 0; k < NOP; k++) cfg_q[k] <= '0;
    end else begin
      err_q <= err_d;
      if (accept) begin
        for (int k = 0; k < NOP; k++) cfg_q[k] <= cfg_in[k];
      end
    end
  end

  assign err = err_q;

  p_oob_sets_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && any_oob) |=> err);
  p_err_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !accept) |=> err);
  p_err_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(busy && any_oob)) |=> !err);

endmodule

// File: tb/vew_seq_bench.sv
`timescale 1ns/1ps
module vew_seq_bench;
  localparam int XLEN = 64, NREGS = 32, VLW = 8, SB = 256;

  logic clk = 0, rst_n = 0, start = 0, ld_en = 0;
  logic [VLW-1:0] vl_i = '0;
  logic [15:0] cd_i = '0, c1_i = '0, c2_i = '0;
  logic [4:0] ld_reg = '0, rd_reg = '0;
  logic [63:0] ld_data = '0;
  logic [63:0] rd_data;
  logic busy, done, err;

  vew_seq #(.XLEN(XLEN), .NREGS(NREGS), .VLW(VLW)) u_vew_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl_i),
    .cfg_dst(cd_i), .cfg_src1(c1_i), .cfg_src2(c2_i),
    .ld_en(ld_en), .ld_reg(ld_reg), .ld_data(ld_data),
    .rd_reg(rd_reg), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err)
  );

  always #2 clk = ~clk;

  typedef struct {
    string       req;
    int          kind;   // 0: store register, 1: direct value
    int          idx;
    logic [63:0] exp;
    logic [63:0] act;
  } item_t;

  item_t q[$];
  int pending = 0, checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] bm [SB];

  function automatic logic [15:0] mkcfg(int ew, int ridx, bit vec);
    return 16'(5'h03 | (ew << 5) | (ridx << 8) | (int'(vec) << 15));
  endfunction

  function automatic int lane(logic [15:0] c);
    case (c[6:5])
      2'd1: return 1;
      2'd2: return 2;
      2'd3: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic logic [63:0] model_reg(int r);
    logic [63:0] v;
    for (int b = 0; b < 8; b++) v[8*b +: 8] = bm[r*8 + b];
    return v;
  endfunction

  function automatic bit model_op(int n, logic [15:0] cd, logic [15:0] c1, logic [15:0] c2);
    bit e = 0;
    for (int i = 0; i < n; i++) begin
      int od = int'(cd[14:8])*8 + (cd[15] ? i*lane(cd) : 0);
      int o1 = int'(c1[14:8])*8 + (c1[15] ? i*lane(c1) : 0);
      int o2 = int'(c2[14:8])*8 + (c2[15] ? i*lane(c2) : 0);
      if (od + lane(cd) > SB || o1 + lane(c1) > SB || o2 + lane(c2) > SB) begin
        e = 1;
      end else begin
        longint a = 0, b2 = 0, s;
        for (int b = 0; b < lane(c1); b++) a  |= longint'(bm[o1+b]) << (8*b);
        for (int b = 0; b < lane(c2); b++) b2 |= longint'(bm[o2+b]) << (8*b);
        if (lane(c1) < 8) a  = (a  << (64 - 8*lane(c1))) >>> (64 - 8*lane(c1));
        if (lane(c2) < 8) b2 = (b2 << (64 - 8*lane(c2))) >>> (64 - 8*lane(c2));
        s = a + b2;
        for (int b = 0; b < lane(cd); b++) bm[od+b] = 8'(s >> (8*b));
      end
    end
    return e;
  endfunction

  task automatic push_val(string req, logic [63:0] act, logic [63:0] exp);
    item_t it;
    it.req = req; it.kind = 1; it.idx = 0; it.exp = exp; it.act = act;
    pending++; q.push_back(it);
  endtask

  task automatic push_regs(string req);
    for (int r = 0; r < NREGS; r++) begin
      item_t it;
      it.req = req; it.kind = 0; it.idx = r; it.exp = model_reg(r); it.act = '0;
      pending++; q.push_back(it);
    end
  endtask

  task automatic drain();
    while (pending != 0) @(negedge clk);
  endtask

  // monitor: pops expected items and compares them against the ports
  initial begin
    forever begin
      item_t it;
      while (q.size() == 0) @(negedge clk);
      it = q.pop_front();
      if (it.kind == 0) begin
        rd_reg = 5'(it.idx);
        #1;
        it.act = rd_data;
      end
      checks++;
      if (it.act !== it.exp) begin
        errors++;
        $display("FAIL %s reg/item %0d: actual %h expected %h", it.req, it.idx, it.act, it.exp);
      end
      pending--;
    end
  end

  task automatic load_reg(int r, logic [63:0] v);
    @(negedge clk);
    ld_en = 1; ld_reg = 5'(r); ld_data = v;
    @(negedge clk);
    ld_en = 0;
    for (int b = 0; b < 8; b++) bm[r*8 + b] = v[8*b +: 8];
  endtask

  task automatic run_op(string req, int n, logic [15:0] cd, logic [15:0] c1, logic [15:0] c2, bit disturb);
    bit e;
    int cnt;
    e = model_op(n, cd, c1, c2);
    @(negedge clk);
    start = 1; vl_i = VLW'(n); cd_i = cd; c1_i = c1; c2_i = c2;
    @(negedge clk);
    start = 0;
    cnt = 0;
    if (disturb) begin  // R10: restart attempt and host load while busy
      start = 1; vl_i = 8'd5; cd_i = mkcfg(0, 0, 1);
      ld_en = 1; ld_reg = 5'd0; ld_data = '1;
    end
    while (!done && cnt < 1000) begin
      @(negedge clk);
      cnt++;
      if (disturb && cnt == 1) begin start = 0; ld_en = 0; end
    end
    push_val({req, " R7 done latency"}, 64'(cnt), 64'(n));
    @(negedge clk);
    push_val({req, " R7 done one cycle"}, {63'b0, done}, 64'b0);
    push_val({req, " R9 err"}, {63'b0, err}, {63'b0, e});
    push_regs({req, " store"});
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    push_val("R11 reset state", {61'b0, busy, done, err}, 64'b0);
    drain();

    for (int r = 0; r < NREGS; r++)
      load_reg(r, 64'hF0E1D2C3B4A59687 ^ (64'(r) * 64'h9E3779B97F4A7C15));

    // R2/R3: full-width vector add
    run_op("R3 full width", 3, mkcfg(0, 1, 1), mkcfg(0, 10, 1), mkcfg(0, 20, 1), 0);
    // R4: scalar first source reused
    run_op("R4 scalar src", 4, mkcfg(3, 2, 1), mkcfg(3, 14, 0), mkcfg(3, 24, 1), 0);
    // R5/R6/R3: mixed widths, destination crosses two register boundaries
    run_op("R5 R6 mixed widths", 10, mkcfg(2, 5, 1), mkcfg(1, 8, 1), mkcfg(3, 12, 1), 0);
    // R1: width value 4 spills into the type bit and decodes as full width
    run_op("R1 spill", 2, mkcfg(4, 3, 1), mkcfg(4, 26, 1), mkcfg(0, 27, 1), 0);
    // R1: 8-bit scalar destination, narrow lanes
    run_op("R1 byte scalar dst", 5, mkcfg(1, 29, 0), mkcfg(1, 30, 1), mkcfg(2, 18, 1), 0);
    // R8: empty operation
    run_op("R8 empty", 0, mkcfg(0, 0, 1), mkcfg(0, 4, 1), mkcfg(0, 6, 1), 0);
    // R9: destination runs off the end of the store
    run_op("R9 overflow", 4, mkcfg(3, 31, 1), mkcfg(3, 9, 1), mkcfg(3, 10, 1), 0);
    // R9 clear and R10 ignored start/load while busy
    run_op("R10 busy ignore", 3, mkcfg(1, 4, 1), mkcfg(1, 16, 1), mkcfg(1, 17, 1), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule